// File: doc/BRIEF.md
# Preset NCO Quadrature Downconverter

This block turns a real, signed 10-bit stream of sampled intermediate-frequency data into complex baseband I and Q. The incoming band sits near a quarter of the sample rate, for example 25 MHz at 100 MHz. Each input sample is multiplied by a cosine and by a negated sine. Both come from a 32-bit phase accumulator whose increment is the wanted offset frequency scaled by 2^32 over the sample rate. The products are rounded, saturated to 12 bits and registered.

The block holds eight 32-bit tuning words in a small bank, loaded one byte at a time. A 3-bit index chooses a word, and it becomes the active increment only on a commit pulse. Software or a hop sequencer can therefore stage the next frequency ahead of time and switch on a chosen cycle. A commit does not clear the accumulator, so the oscillator phase stays continuous across a hop.

A rate input chooses the output cadence. In full-rate mode every input sample yields an output. In reduced mode a fixed 2-of-5 cycle pattern gates the valid strobe, which gives 40 MS/s from a 100 MHz clock.

Top module: `preset_nco_ddc`

## Requirements
- R1: While `rst` is high at a rising edge, the following are all cleared: `out_valid`, `i_out`, `q_out`, the phase accumulator, the active increment and the rate-pattern counter.
- R2: When `cfg_we` is high at a rising edge, `cfg_wdata` is written into one byte of one tuning word. `cfg_addr[4:2]` selects the word (0 to 7) and `cfg_addr[1:0]` selects the byte, where 0 is bits 7:0 and 3 is bits 31:24.
- R3: A `tune_commit` pulse copies the word selected by `tune_sel` into the active increment. Without a commit the active increment does not change, even when the active word's bank entry is rewritten. If a commit and a write to the same word happen in one cycle, the commit takes the contents held before that write.
- R4: At every rising edge out of reset, the accumulator adds the active increment, modulo 2^32. A commit never resets the accumulator.
- R5: The sample captured at an edge is paired with the accumulator value held before that edge. Let p be accumulator bits 31:22. The cosine value is round(2047·cos(2πp/1024)) and the sine value is round(2047·sin(2πp/1024)), with ties rounded away from zero. They are built from a 256-entry quarter-wave table.
- R6: With input x, cosine C and sine S, `i_out` = sat12((x·C + 128) >>> 8) and `q_out` = sat12((−x·S + 128) >>> 8). Here sat12 clamps to the range −2048 to 2047.
- R7: A sample presented before rising edge E appears on `i_out`/`q_out` with `out_valid` high right after edge E+2.
- R8: With `full_rate` high at the capture edge, every captured sample produces a valid output.
- R9: With `full_rate` low, number the out-of-reset edges c = 0, 1, 2, and so on. Only samples captured at edges with c mod 5 equal to 0 or 2 produce a valid output, which is 20 outputs in any 50 consecutive captures.
- R10: While `out_valid` is low, `i_out` and `q_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Byte write strobe for the tuning-word bank |
| cfg_addr | input | 5 | Word index (bits 4:2) and byte index (bits 1:0) |
| cfg_wdata | input | 8 | Byte to write |
| tune_sel | input | 3 | Index of the word to commit |
| tune_commit | input | 1 | Loads the selected word into the active increment |
| full_rate | input | 1 | 1: output every sample; 0: 2-of-5 output pattern |
| adc_data | input | 10 | Signed IF input sample |
| out_valid | output | 1 | Output sample strobe |
| i_out | output | 12 | Signed in-phase result |
| q_out | output | 12 | Signed quadrature result |

## Verification
The bench drives samples at the two full-scale extremes while the phase sits on each quadrant boundary. A wrong sign on the quadrature product, a missing saturation clamp or a mirrored-table off-by-one would each make these results wrap or flip. It rewrites the live tuning word without a commit, and in a second case writes and commits the same word in one cycle. A bank that leaked into the active increment, or a commit that read the new byte, would shift the phase of every later sample. Reduced-rate runs check both the count and the position of the 2-of-5 strobes, and the bench checks that idle outputs hold their last value. A latency stamp on every expected item catches one pipeline register too many or too few.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Entry k of a quarter-wave table with 2**aw entries over [0, pi/2),
  // scaled by amp and rounded half away from zero.
  function automatic int quarter_sine(input int aw, input int amp, input int k);
    real ang;
    real v;
    ang = (PI_R / 2.0) * real'(k) / real'(1 << aw);
    v   = real'(amp) * $sin(ang);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

endpackage

// File: rtl/ddc_preset_bank.sv
module ddc_preset_bank #(
  parameter int NPRE = 8,
  parameter int PW   = 32,
  localparam int NB  = PW / 8,
  localparam int BAW = $clog2(NB),
  localparam int SAW = $clog2(NPRE),
  localparam int AW  = SAW + BAW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic [SAW-1:0] sel,
  output logic [PW-1:0] step_word
);

  logic [PW-1:0]  bank [NPRE];
  logic [SAW-1:0] w_slot;
  logic [BAW-1:0] w_byte;

  assign w_slot = wr_addr[AW-1:BAW];
  assign w_byte = wr_addr[BAW-1:0];

  // Byte-lane write, no reset, so the bank may map onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      bank[w_slot][{w_byte, 3'b000} +: 8] <= wr_data;
    end
  end

  // Active increment: changes only on commit and reads the pre-write contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      step_word <= '0;
    end else if (commit) begin
      step_word <= bank[sel];
    end
  end

endmodule

// File: rtl/ddc_phase_wave.sv
module ddc_phase_wave #(
  parameter int PW     = 32,
  parameter int LUT_AW = 8,
  parameter int SW     = 12,
  localparam int AMP   = (1 << (SW - 1)) - 1,
  localparam int QN    = 1 << LUT_AW,
  localparam int PAW   = LUT_AW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        step_word,
  output logic [PW-1:0]        phase,
  output logic signed [SW-1:0] cos_q,
  output logic signed [SW-1:0] sin_q
);

  logic signed [SW-1:0] qtab [QN];

  for (genvar k = 0; k < QN; k++) begin : g_tab
    assign qtab[k] = SW'(ddc_pkg::quarter_sine(LUT_AW, AMP, k));
  end

  // Full-circle sine from the quarter table: the low address bit of the
  // quadrant mirrors the index, the high bit negates the result.
  function automatic logic signed [SW-1:0] wave(input logic [PAW-1:0] a);
    logic [LUT_AW-1:0]    k;
    logic [LUT_AW-1:0]    kr;
    logic signed [SW-1:0] mag;
    k  = a[LUT_AW-1:0];
    kr = ~k + 1'b1;
    if (a[LUT_AW]) begin
      mag = (k == '0) ? SW'(AMP) : qtab[kr];
    end else begin
      mag = qtab[k];
    end
    return a[PAW-1] ? -mag : mag;
  endfunction

  logic [PW-1:0]  acc;
  logic [PAW-1:0] a_sin;
  logic [PAW-1:0] a_cos;

  assign a_sin = acc[PW-1 -: PAW];
  assign a_cos = a_sin + PAW'(QN);
  assign phase = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      acc   <= acc + step_word;
      sin_q <= wave(a_sin);
      cos_q <= wave(a_cos);
    end
  end

endmodule

// File: rtl/ddc_rate_gate.sv
module ddc_rate_gate #(
  parameter int GLEN                = 5,
  parameter logic [GLEN-1:0] GMASK  = 5'b00101,
  localparam int CW                 = $clog2(GLEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic full_rate,
  output logic keep
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      cnt <= (cnt == CW'(GLEN - 1)) ? '0 : cnt + 1'b1;
    end
  end

  assign keep = full_rate | GMASK[cnt];

endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
  parameter int DW    = 10,
  parameter int SW    = 12,
  parameter int OW    = 12,
  parameter int SHIFT = 8,
  localparam int MW   = DW + SW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_keep,
  input  logic signed [DW-1:0] x,
  input  logic signed [SW-1:0] cos_v,
  input  logic signed [SW-1:0] sin_v,
  output logic                 out_valid,
  output logic signed [OW-1:0] i_out,
  output logic signed [OW-1:0] q_out
);

  localparam logic signed [MW-1:0] TOP = MW'((1 << (OW - 1)) - 1);
  localparam logic signed [MW-1:0] BOT = -MW'(1 << (OW - 1));
  localparam logic signed [MW-1:0] RND = MW'(1 << (SHIFT - 1));

  function automatic logic signed [OW-1:0] shrink(input logic signed [MW-1:0] p);
    logic signed [MW-1:0] r;
    r = (p + RND) >>> SHIFT;
    if (r > TOP) begin
      return TOP[OW-1:0];
    end else if (r < BOT) begin
      return BOT[OW-1:0];
    end
    return r[OW-1:0];
  endfunction

  logic signed [MW-1:0] prod_i;
  logic signed [MW-1:0] prod_q;
  logic                 keep_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_i    <= '0;
      prod_q    <= '0;
      keep_r    <= 1'b0;
      out_valid <= 1'b0;
      i_out     <= '0;
      q_out     <= '0;
    end else begin
      prod_i    <= x * cos_v;
      prod_q    <= -(x * sin_v);
      keep_r    <= in_keep;
      out_valid <= keep_r;
      if (keep_r) begin
        i_out <= shrink(prod_i);
        q_out <= shrink(prod_q);
      end
    end
  end

endmodule

// File: rtl/preset_nco_ddc.sv
module preset_nco_ddc #(
  parameter int IN_W        = 10,
  parameter int OUT_W       = 12,
  parameter int PHASE_W     = 32,
  parameter int NUM_PRESETS = 8,
  parameter int LUT_ADDR_W  = 8,
  parameter int WAVE_W      = 12,
  parameter int PROD_SHIFT  = 8,
  parameter int GATE_LEN    = 5,
  parameter logic [GATE_LEN-1:0] GATE_MASK = 5'b00101,
  localparam int SEL_W      = $clog2(NUM_PRESETS),
  localparam int CFG_AW     = SEL_W + $clog2(PHASE_W / 8)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [7:0]              cfg_wdata,
  input  logic [SEL_W-1:0]        tune_sel,
  input  logic                    tune_commit,
  input  logic                    full_rate,
  input  logic signed [IN_W-1:0]  adc_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out
);

  logic [PHASE_W-1:0]       step_word;
  logic [PHASE_W-1:0]       phase;
  logic signed [WAVE_W-1:0] cos_v;
  logic signed [WAVE_W-1:0] sin_v;
  logic                     keep;
  logic signed [IN_W-1:0]   x_q;
  logic                     keep_q;

  ddc_preset_bank #(.NPRE(NUM_PRESETS), .PW(PHASE_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_wdata),
    .commit    (tune_commit),
    .sel       (tune_sel),
    .step_word (step_word)
  );

  ddc_phase_wave #(.PW(PHASE_W), .LUT_AW(LUT_ADDR_W), .SW(WAVE_W)) u_wave (
    .clk       (clk),
    .rst       (rst),
    .step_word (step_word),
    .phase     (phase),
    .cos_q     (cos_v),
    .sin_q     (sin_v)
  );

  ddc_rate_gate #(.GLEN(GATE_LEN), .GMASK(GATE_MASK)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .full_rate (full_rate),
    .keep      (keep)
  );

  // Capture stage, aligned with the registered table outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      keep_q <= 1'b0;
    end else begin
      x_q    <= adc_data;
      keep_q <= keep;
    end
  end

  ddc_mixer #(.DW(IN_W), .SW(WAVE_W), .OW(OUT_W), .SHIFT(PROD_SHIFT)) u_mix (
    .clk       (clk),
    .rst       (rst),
    .in_keep   (keep_q),
    .x         (x_q),
    .cos_v     (cos_v),
    .sin_v     (sin_v),
    .out_valid (out_valid),
    .i_out     (i_out),
    .q_out     (q_out)
  );

endmodule

// File: rtl/ddc_checker.sv
module ddc_checker #(
  parameter int PW = 32,
  parameter int OW = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 commit,
  input logic                 full_rate,
  input logic                 out_valid,
  input logic signed [OW-1:0] i_out,
  input logic signed [OW-1:0] q_out,
  input logic [PW-1:0]        step_word,
  input logic [PW-1:0]        phase
);

  // Count of out-of-reset edges, saturating, to bound every $past window.
  logic [2:0] since;
  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
    end else if (since != 3'd7) begin
      since <= since + 3'd1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && i_out == '0 && q_out == '0 && phase == '0 && step_word == '0));

  p_step_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd1 && !$past(commit)) |-> $stable(step_word));

  p_phase_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd1) |-> (phase == $past(phase) + $past(step_word)));

  p_full_rate_r8: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd3 && $past(full_rate, 3)) |-> out_valid);

  p_no_adjacent_r9: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd4 && out_valid && $past(out_valid)) |-> ($past(full_rate, 3) || $past(full_rate, 4)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (since >= 3'd1 && !out_valid) |-> ($stable(i_out) && $stable(q_out)));

endmodule

bind preset_nco_ddc ddc_checker #(.PW(PHASE_W), .OW(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .commit    (tune_commit),
  .full_rate (full_rate),
  .out_valid (out_valid),
  .i_out     (i_out),
  .q_out     (q_out),
  .step_word (step_word),
  .phase     (phase)
);

// File: tb/sim_preset_nco_ddc.sv
`timescale 1ns/1ps
module sim_preset_nco_ddc;

  localparam real TWO_PI = 6.28318530717958647692;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [4:0]        cfg_addr = '0;
  logic [7:0]        cfg_wdata = '0;
  logic [2:0]        tune_sel = '0;
  logic              tune_commit = 1'b0;
  logic              full_rate = 1'b1;
  logic signed [9:0] adc_data = '0;
  logic              out_valid;
  logic signed [11:0] i_out;
  logic signed [11:0] q_out;

  always #10 clk = ~clk;

  preset_nco_ddc u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tune_sel(tune_sel), .tune_commit(tune_commit),
    .full_rate(full_rate), .adc_data(adc_data), .out_valid(out_valid),
    .i_out(i_out), .q_out(q_out)
  );

  typedef struct { int ei; int eq; longint t; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int vcount = 0;
  int last_i = 0;
  int last_q = 0;

  logic [31:0] acc_m = '0;
  logic [31:0] step_m = '0;
  logic [31:0] pm [8];
  int cyc_m = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  function automatic int mix(input int x, input int w);
    longint p;
    longint r;
    p = longint'(x) * longint'(w);
    r = (p + 128) >>> 8;
    if (r > 2047) return 2047;
    if (r < -2048) return -2048;
    return int'(r);
  endfunction

  function automatic int xs(input int n);
    return ((n * 73 + 19) % 1024) - 512;
  endfunction

  // Driver: called at a falling edge; the next rising edge captures.
  task automatic step(input int x, input bit cm = 1'b0, input int s = 0,
                      input bit we = 1'b0, input int addr = 0, input int data = 0);
    int p;
    int cc;
    int ss;
    bit keep;
    adc_data    = x[9:0];
    tune_commit = cm;
    tune_sel    = s[2:0];
    cfg_we      = we;
    cfg_addr    = addr[4:0];
    cfg_wdata   = data[7:0];
    p  = int'(acc_m[31:22]);
    cc = rnd(2047.0 * $cos(TWO_PI * real'(p) / 1024.0));
    ss = rnd(2047.0 * $sin(TWO_PI * real'(p) / 1024.0));
    keep = full_rate || (cyc_m % 5 == 0) || (cyc_m % 5 == 2);
    if (keep) sb.push_back('{ei: mix(x, cc), eq: mix(x, -ss), t: longint'($time)});
    acc_m = acc_m + step_m;
    if (cm) step_m = pm[s];
    if (we) pm[addr >> 2][(addr & 3) * 8 +: 8] = data[7:0];
    cyc_m++;
    @(negedge clk);
  endtask

  task automatic put_word(input int slot, input logic [31:0] w, input int x0);
    for (int b = 0; b < 4; b++) step(xs(x0 + b), 1'b0, 0, 1'b1, slot * 4 + b, int'(w[b*8 +: 8]));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_on) begin
        if (out_valid) begin
          vcount++;
          if (sb.size() == 0) begin
            check(1'b0, "R8", "valid with nothing expected", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(i_out) == e.ei, "R6", "I value", i_out, e.ei);
            check(int'(q_out) == e.eq, "R6", "Q value", q_out, e.eq);
            check(longint'($time) - e.t == 61, "R7", "latency ns", longint'($time) - e.t, 61);
          end
          last_i = int'(i_out);
          last_q = int'(q_out);
        end else begin
          check(int'(i_out) == last_i && int'(q_out) == last_q, "R10", "idle hold I",
                i_out, last_i);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v0;
    for (int k = 0; k < 8; k++) pm[k] = '0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    check(i_out == '0 && q_out == '0, "R1", "I in reset", i_out, 0);
    rst = 1'b0;
    mon_on = 1'b1;

    // R1/R6: zero increment keeps phase 0 (C=2047, S=0); extremes saturate
    step(0); step(511); step(-512); step(100); step(-100); step(255); step(-1); step(1);

    // R2: load word 1 with a quarter turn; R3: not live before commit
    put_word(1, 32'h4000_0000, 10);
    put_word(3, 32'h2000_0000, 20);
    step(300);
    step(7, 1'b1, 1);
    // R4/R5: quadrant boundaries 0, 90, 180, 270 degrees with extremes
    for (int n = 0; n < 4; n++) step(511);
    for (int n = 0; n < 4; n++) step(-512);
    for (int n = 0; n < 8; n++) step(xs(n));

    // R3: switch to an arbitrary word, then rewrite it without commit
    put_word(2, 32'h0A3D_70A4, 30);
    step(xs(40), 1'b1, 2);
    for (int n = 0; n < 6; n++) step(xs(50 + n));
    put_word(2, 32'h1111_1111, 60);
    for (int n = 0; n < 10; n++) step(xs(70 + n));
    step(xs(80), 1'b1, 2);
    for (int n = 0; n < 6; n++) step(xs(90 + n));
    // R3: commit word 3 in the same cycle as a byte write to it
    step(xs(100), 1'b1, 3, 1'b1, 12, 8'h55);
    for (int n = 0; n < 8; n++) step(xs(110 + n));

    // R9: reduced rate, pattern position via scoreboard, density by count
    full_rate = 1'b0;
    for (int n = 0; n < 3; n++) step(xs(120 + n));
    v0 = vcount;
    for (int n = 0; n < 50; n++) step(xs(130 + n));
    check(vcount - v0 == 20, "R9", "valids in 50 reduced cycles", vcount - v0, 20);
    step(xs(200), 1'b1, 1);
    for (int n = 0; n < 12; n++) step(xs(210 + n));

    // R8: back to full rate; pending count after the last three samples
    full_rate = 1'b1;
    for (int n = 0; n < 12; n++) step(xs(230 + n));
    mon_on = 1'b0;
    check(sb.size() == 3, "R8", "pending results", sb.size(), 3);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule